// File: doc/BRIEF.md
# Iterative Integer Multiply/Divide Unit

This unit computes 32-bit integer products and quotients over many cycles. A single start pulse selects one of four operations: signed multiply, unsigned multiply, signed divide or unsigned divide. The same pulse supplies two operands. Both multiply and divide run on one shared 64-bit working register and a single adder/subtractor. Results go into two architectural registers, HI and LO. These can be read at any time and hold their value until the next operation finishes.

Multiplication retires one multiplier bit per cycle by conditional add and right shift. Division produces one quotient bit per cycle by left shift, trial subtract and restore. Signed operations first convert both operands to magnitudes, then run the unsigned loop, and finally correct the signs of the results. The unit raises no error for a zero divisor or a quotient that does not fit. Such cases give a fixed, predictable result, and software is expected to screen for them.

Top module: `muldiv_iter`

## Requirements
- R1: During and directly after reset, `busy` and `done` are 0 and `hi` and `lo` are 0.
- R2: The unsigned multiply operation (`op` = 1) leaves the 64-bit unsigned product of `opa` and `opb` in `hi` (upper 32 bits) and `lo` (lower 32 bits).
- R3: The signed multiply operation (`op` = 0) leaves the 64-bit two's-complement product of `opa` and `opb` in `hi`/`lo`. This includes the most negative operand values.
- R4: The unsigned divide operation (`op` = 3) with `opb` nonzero places `opa / opb` in `lo` and `opa mod opb` in `hi`.
- R5: The signed divide operation (`op` = 2) with `opb` nonzero gives a quotient truncated toward zero in `lo` and a remainder with the sign of the dividend in `hi`. The case 0x80000000 / 0xFFFFFFFF wraps to a quotient of 0x80000000 with remainder 0.
- R6: A zero divisor raises no flag. For unsigned divide, `lo` becomes 0xFFFFFFFF and `hi` becomes `opa`. For signed divide, `hi` becomes `opa`; `lo` becomes 0xFFFFFFFF when `opa` is non-negative and 0x00000001 when `opa` is negative.
- R7: A start taken at a clock edge raises `busy` for exactly 33 cycles (one setup cycle and 32 iteration cycles). In the cycle after the last of these, `busy` is 0, `done` is 1 for that single cycle, and `hi`/`lo` already hold the result.
- R8: A `start` asserted while `busy` is 1 is ignored. The running operation completes on its original schedule with its original operands and operation.
- R9: `hi` and `lo` change only in a cycle where `done` is 1. They keep the previous result while idle and throughout a following operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin an operation; sampled only while idle |
| op | input | 2 | 0 signed mul, 1 unsigned mul, 2 signed div, 3 unsigned div |
| opa | input | 32 | Multiplier or dividend |
| opb | input | 32 | Multiplicand or divisor |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse: new result in `hi`/`lo` |
| hi | output | 32 | Upper product half or remainder |
| lo | output | 32 | Lower product half or quotient |

## Verification
The hardest case to reach from the ports is a second `start` landing in the middle of a running operation. To check it, the bench must show that nothing was recaptured, and the only visible evidence of that is the final result and the cycle it arrives in. The bench launches one operation, then pulses `start` several cycles later with different operands and a different operation. It then requires `done` on the original cycle with the original result. The sign-correction corner cases also need deliberate operands: the most negative value, minus one, and a zero divisor with both signs of dividend. These sit next to ordinary mixed-sign pairs.

// File: rtl/muldiv_pkg.sv
// Package: shared operation codes and control states for the iterative
// multiply/divide unit. Assumes a 2-bit operation field.
package muldiv_pkg;

    typedef enum logic [1:0] {
        OP_MUL_S = 2'd0,
        OP_MUL_U = 2'd1,
        OP_DIV_S = 2'd2,
        OP_DIV_U = 2'd3
    } md_op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_RUN   = 2'd2
    } md_state_e;

    // True for the two divide codes.
    function automatic logic op_is_div(input md_op_e o);
        return (o == OP_DIV_S) || (o == OP_DIV_U);
    endfunction

    // True for the two signed codes.
    function automatic logic op_is_signed(input md_op_e o);
        return (o == OP_MUL_S) || (o == OP_DIV_S);
    endfunction

endpackage

// File: rtl/muldiv_prep.sv
// Operand preparation: converts each operand to its magnitude for signed
// codes and derives which results need negation afterwards.
// Assumes two's-complement operands; the magnitude of the most negative
// value is representable as an unsigned WIDTH-bit number.
module muldiv_prep
    import muldiv_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  md_op_e           op,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] mag_a,
    output logic [WIDTH-1:0] mag_b,
    output logic             neg_main,
    output logic             neg_rem
);

    logic sgn_a;
    logic sgn_b;

    // Sign of each operand as seen by the selected code.
    always_comb begin
        sgn_a = op_is_signed(op) & a[WIDTH-1];
        sgn_b = op_is_signed(op) & b[WIDTH-1];
    end

    // Magnitudes and negation flags.
    always_comb begin
        mag_a    = sgn_a ? (~a + 1'b1) : a;
        mag_b    = sgn_b ? (~b + 1'b1) : b;
        neg_main = sgn_a ^ sgn_b;
        neg_rem  = sgn_a;
    end

endmodule

// File: rtl/muldiv_step.sv
// One iteration of the shared datapath. Multiply: conditional add of the
// multiplicand into the upper half, then shift right. Divide: shift left,
// trial subtract, keep or restore, insert quotient bit.
// Assumes the working register holds {upper, lower} halves of WIDTH bits.
module muldiv_step #(
    parameter int WIDTH = 32,
    localparam int AW   = 2 * WIDTH
) (
    input  logic             is_div,
    input  logic [AW-1:0]    acc,
    input  logic [WIDTH-1:0] opd,
    output logic [AW-1:0]    acc_next
);

    logic [WIDTH:0] mul_sum;
    logic [WIDTH:0] div_shift;
    logic [WIDTH:0] div_diff;
    logic           div_ge;
    logic [WIDTH-1:0] div_hi;

    // Multiply step: carry of the add becomes the top bit after shifting.
    always_comb begin
        if (acc[0]) mul_sum = {1'b0, acc[AW-1:WIDTH]} + {1'b0, opd};
        else        mul_sum = {1'b0, acc[AW-1:WIDTH]};
    end

    // Divide step: shifted partial remainder compared with the divisor.
    always_comb begin
        div_shift = acc[AW-1:WIDTH-1];
        div_diff  = div_shift - {1'b0, opd};
        div_ge    = (div_shift >= {1'b0, opd});
        div_hi    = div_ge ? div_diff[WIDTH-1:0] : div_shift[WIDTH-1:0];
    end

    // Select the step result.
    always_comb begin
        if (is_div) acc_next = {div_hi, acc[WIDTH-2:0], div_ge};
        else        acc_next = {mul_sum, acc[WIDTH-1:1]};
    end

endmodule

// File: rtl/muldiv_fixup.sv
// Result correction: applies the sign correction to the unsigned loop
// result and splits it into the HI and LO values.
// Assumes the working register holds remainder:quotient after a divide
// and the full product after a multiply.
module muldiv_fixup #(
    parameter int WIDTH = 32,
    localparam int AW   = 2 * WIDTH
) (
    input  logic             is_div,
    input  logic             neg_main,
    input  logic             neg_rem,
    input  logic [AW-1:0]    acc,
    output logic [WIDTH-1:0] res_hi,
    output logic [WIDTH-1:0] res_lo
);

    logic [AW-1:0]    prod;
    logic [WIDTH-1:0] quo;
    logic [WIDTH-1:0] rem;

    // Signed corrections for both result kinds.
    always_comb begin
        prod = neg_main ? (~acc + 1'b1) : acc;
        quo  = neg_main ? (~acc[WIDTH-1:0] + 1'b1) : acc[WIDTH-1:0];
        rem  = neg_rem  ? (~acc[AW-1:WIDTH] + 1'b1) : acc[AW-1:WIDTH];
    end

    // Route the corrected values to HI/LO.
    always_comb begin
        if (is_div) begin
            res_hi = rem;
            res_lo = quo;
        end else begin
            res_hi = prod[AW-1:WIDTH];
            res_lo = prod[WIDTH-1:0];
        end
    end

endmodule

// File: rtl/muldiv_iter.sv
// Top of the iterative multiply/divide unit. Captures a start request
// while idle, spends one setup cycle loading magnitudes, runs WIDTH
// iterations of the shared step, then writes HI/LO and pulses done.
// Assumes start is ignored whenever busy is high; no error is flagged.
module muldiv_iter
    import muldiv_pkg::*;
#(
    parameter int WIDTH = 32,
    localparam int AW    = 2 * WIDTH,
    localparam int CNT_W = $clog2(WIDTH),
    localparam int LEN_W = $clog2(WIDTH + 2) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [1:0]       op,
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    output logic             busy,
    output logic             done,
    output logic [WIDTH-1:0] hi,
    output logic [WIDTH-1:0] lo
);

    md_state_e        state;
    md_op_e           cap_op;
    logic [WIDTH-1:0] cap_a;
    logic [WIDTH-1:0] cap_b;
    logic [AW-1:0]    acc;
    logic [WIDTH-1:0] opd;
    logic [CNT_W-1:0] cnt;

    logic [WIDTH-1:0] mag_a;
    logic [WIDTH-1:0] mag_b;
    logic             neg_main;
    logic             neg_rem;
    logic             is_div;
    logic [AW-1:0]    acc_next;
    logic [WIDTH-1:0] res_hi;
    logic [WIDTH-1:0] res_lo;
    logic             last_step;

    // Control decodes.
    assign is_div    = op_is_div(cap_op);
    assign busy      = (state != ST_IDLE);
    assign last_step = (cnt == CNT_W'(WIDTH - 1));

    muldiv_prep #(.WIDTH(WIDTH)) u_prep (
        .op       (cap_op),
        .a        (cap_a),
        .b        (cap_b),
        .mag_a    (mag_a),
        .mag_b    (mag_b),
        .neg_main (neg_main),
        .neg_rem  (neg_rem)
    );

    muldiv_step #(.WIDTH(WIDTH)) u_step (
        .is_div   (is_div),
        .acc      (acc),
        .opd      (opd),
        .acc_next (acc_next)
    );

    muldiv_fixup #(.WIDTH(WIDTH)) u_fixup (
        .is_div   (is_div),
        .neg_main (neg_main),
        .neg_rem  (neg_rem),
        .acc      (acc_next),
        .res_hi   (res_hi),
        .res_lo   (res_lo)
    );

    // Sequencer, working registers and HI/LO result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            cap_op <= OP_MUL_S;
            cap_a  <= '0;
            cap_b  <= '0;
            acc    <= '0;
            opd    <= '0;
            cnt    <= '0;
            done   <= 1'b0;
            hi     <= '0;
            lo     <= '0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        cap_op <= md_op_e'(op);
                        cap_a  <= opa;
                        cap_b  <= opb;
                        state  <= ST_SETUP;
                    end
                end
                ST_SETUP: begin
                    acc   <= {{WIDTH{1'b0}}, mag_a};
                    opd   <= mag_b;
                    cnt   <= '0;
                    state <= ST_RUN;
                end
                ST_RUN: begin
                    acc <= acc_next;
                    cnt <= cnt + 1'b1;
                    if (last_step) begin
                        hi    <= res_hi;
                        lo    <= res_lo;
                        done  <= 1'b1;
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Checker support: length of the current busy window.
    logic [LEN_W-1:0] busy_len;
    always_ff @(posedge clk) begin
        if (!rst_n)     busy_len <= '0;
        else if (!busy) busy_len <= '0;
        else            busy_len <= busy_len + 1'b1;
    end

    AST_DONE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && busy_len == LEN_W'(WIDTH + 1))); // R7
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(cap_a) && $stable(cap_b) && $stable(cap_op))); // R8
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(hi) && $stable(lo))); // R9
    AST_REM_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && is_div && opd != '0) |-> (acc[AW-1:WIDTH] < opd)); // R4

endmodule

// File: tb/muldiv_iter_bench.sv
// Directed bench for the iterative multiply/divide unit.
module muldiv_iter_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  op = 2'd0;
    logic [31:0] opa = '0;
    logic [31:0] opb = '0;
    logic        busy;
    logic        done;
    logic [31:0] hi;
    logic [31:0] lo;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    muldiv_iter u_muldiv_iter (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op),
        .opa(opa), .opb(opb), .busy(busy), .done(done), .hi(hi), .lo(lo)
    );

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Reference results from the requirement text.
    task automatic model(input logic [1:0] o, input logic [31:0] a, input logic [31:0] b,
                         output logic [31:0] eh, output logic [31:0] el);
        logic [63:0] p;
        logic signed [63:0] sa, sb, q, r;
        sa = {{32{a[31]}}, a};
        sb = {{32{b[31]}}, b};
        case (o)
            2'd1: begin p = {32'd0, a} * {32'd0, b}; eh = p[63:32]; el = p[31:0]; end
            2'd0: begin p = sa * sb; eh = p[63:32]; el = p[31:0]; end
            2'd3: begin
                if (b == 0) begin eh = a; el = 32'hFFFF_FFFF; end
                else begin eh = a % b; el = a / b; end
            end
            default: begin
                if (b == 0) begin eh = a; el = a[31] ? 32'h1 : 32'hFFFF_FFFF; end
                else begin q = sa / sb; r = sa % sb; eh = r[31:0]; el = q[31:0]; end
            end
        endcase
    endtask

    function automatic string req_of(input logic [1:0] o, input logic [31:0] b);
        if (o >= 2 && b == 0) return "R6";
        case (o)
            2'd0: return "R3";
            2'd1: return "R2";
            2'd2: return "R5";
            default: return "R4";
        endcase
    endfunction

    // Launch one operation; optionally pulse a stray start mid-run; check
    // busy window, done pulse, result and hold afterwards.
    task automatic run_op(input logic [1:0] o, input logic [31:0] a, input logic [31:0] b,
                          input int stray_at);
        logic [31:0] eh, el, old_hi, old_lo;
        int bad_busy;
        string rq;
        model(o, a, b, eh, el);
        rq = req_of(o, b);
        old_hi = hi;
        old_lo = lo;
        @(negedge clk);
        start = 1'b1; op = o; opa = a; opb = b;
        @(negedge clk);
        start = 1'b0; opa = ~a; opb = b ^ 32'h5A5A_0F0F; op = ~o;
        bad_busy = (busy === 1'b1 && done === 1'b0) ? 0 : 1;
        for (int k = 1; k < 33; k++) begin
            if (k == stray_at) begin
                start = 1'b1;
                @(negedge clk);
                start = 1'b0;
            end else begin
                @(negedge clk);
            end
            if (!(busy === 1'b1 && done === 1'b0)) bad_busy++;
            if (k == 16) check("R9", "hi/lo held during run", {hi, lo}, {old_hi, old_lo});
        end
        check("R7", "busy for 33 cycles", 64'(bad_busy), 64'd0);
        @(negedge clk);
        check("R7", "done pulse, busy low", {62'd0, busy, done}, 64'd1);
        check(stray_at > 0 ? "R8" : rq, "hi", {32'd0, hi}, {32'd0, eh});
        check(stray_at > 0 ? "R8" : rq, "lo", {32'd0, lo}, {32'd0, el});
        @(negedge clk);
        check("R7", "done lasts one cycle", {63'd0, done}, 64'd0);
        repeat (3) @(negedge clk);
        check("R9", "hi/lo held when idle", {hi, lo}, {eh, el});
    endtask

    task automatic test_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1", "in reset", {busy, done, hi, lo}, 66'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "after reset", {busy, done, hi, lo}, 66'd0);
    endtask

    task automatic test_mul_unsigned();
        run_op(2'd1, 32'd11, 32'd13, 0);
        run_op(2'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0);
        run_op(2'd1, 32'h1234_5678, 32'h9ABC_DEF0, 0);
        run_op(2'd1, 32'd0, 32'hDEAD_BEEF, 0);
    endtask

    task automatic test_mul_signed();
        run_op(2'd0, 32'hFFFF_FFFD, 32'd7, 0);
        run_op(2'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0);
        run_op(2'd0, 32'h8000_0000, 32'h8000_0000, 0);
        run_op(2'd0, 32'h7FFF_FFFF, 32'h8000_0000, 0);
    endtask

    task automatic test_div_unsigned();
        run_op(2'd3, 32'd7, 32'd2, 0);
        run_op(2'd3, 32'hFFFF_FFFF, 32'd10, 0);
        run_op(2'd3, 32'd5, 32'hFFFF_FFFF, 0);
        run_op(2'd3, 32'hFFFF_FFFE, 32'hFFFF_FFFF, 0);
    endtask

    task automatic test_div_signed();
        run_op(2'd2, 32'hFFFF_FFF9, 32'd2, 0);
        run_op(2'd2, 32'd7, 32'hFFFF_FFFE, 0);
        run_op(2'd2, 32'hFFFF_FFF9, 32'hFFFF_FFFE, 0);
        run_op(2'd2, 32'h8000_0000, 32'hFFFF_FFFF, 0);
        run_op(2'd2, 32'd100, 32'd7, 0);
    endtask

    task automatic test_div_zero();
        run_op(2'd3, 32'h0BAD_F00D, 32'd0, 0);
        run_op(2'd2, 32'd1234, 32'd0, 0);
        run_op(2'd2, 32'hFFFF_FF00, 32'd0, 0);
    endtask

    task automatic test_start_while_busy();
        run_op(2'd1, 32'h0000_FFFF, 32'h0001_0001, 5);
        run_op(2'd2, 32'hFFFF_FF9C, 32'd9, 31);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        test_reset();
        test_mul_unsigned();
        test_mul_signed();
        test_div_unsigned();
        test_div_signed();
        test_div_zero();
        test_start_while_busy();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule